// File: doc/BRIEF.md
# Counting Level-Sensitive Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt lines (64 by default) into a single request to the processor. Every line has an enable bit of its own. Each clock the block samples the lines. It keeps the sampled level of every line and a running tally of the lines that are both enabled and high. The tally changes by one step for each level change and each enable change. It is never recomputed from a bitmask. The processor request output is high whenever the tally is non-zero.

Software reaches the block over a plain register bus of 32-bit words inside a 4 KiB window. The word index is the byte address shifted right by two. Word 0 returns a fixed identification value. Word 1 returns the tally. Word 2 returns the lowest-numbered line that is enabled and high. Writes to words 3, 4 and 5 are commands: disable every line, disable one line, and enable one line. For the two single-line commands, the line number travels in the write data. The bus has no back-pressure: a write is taken in the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`, so it is valid in the same cycle.

Top module: `irq_count_ctrl`

## Requirements
- R1: After reset, all enables, all sampled levels and the tally are zero, `irq_out` is low, and word 2 reads 0xFFFFFFFF.
- R2: Word 0 reads the constant `ID_WORD` (default 0x1C5A0001). Any word index above 5 reads zero. A write to words 0, 1, 2 or above 5 changes no state.
- R3: `irq_out` is registered and is high exactly when the tally held in the same cycle is non-zero. It changes in the clock edge that changes the tally.
- R4: Each clock, a line whose input differs from its sampled level takes the new level. If the line is enabled, the tally rises by one on a 0-to-1 change and falls by one on a 1-to-0 change. On a disabled line the level is stored and the tally is unchanged.
- R5: A write to word 5 with data D below `N_LINES` enables line D and adds one to the tally if that line's level is high. It does nothing if line D is already enabled or if D is `N_LINES` or more, and the data is not truncated to the index width.
- R6: A write to word 4 with data D below `N_LINES` disables line D and takes one from the tally if that line's level is high. It does nothing if line D is already disabled or if D is out of range.
- R7: A write to word 3, with any data, clears every enable and sets the tally to zero. Sampled levels are kept, so enabling a line that is still high afterwards counts it again.
- R8: Word 2 reads the lowest line index whose sampled level and enable are both 1, or 0xFFFFFFFF when there is none.
- R9: When a level change and a command land in the same clock, both take effect. After every edge the tally equals the number of lines that are enabled and high.
- R10: Register selection uses byte-address bits [11:2], and bits [1:0] are ignored. Line `N_LINES`-1 behaves like every other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Level-sensitive interrupt lines, one bit per line |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr | input | ADDR_W | Byte address within the 4 KiB window |
| bus_wdata | input | 32 | Write data: the line number for single-line commands |
| bus_rdata | output | 32 | Read data for the word at `bus_addr`, combinational |
| irq_out | output | 1 | Request to the processor, high while the tally is non-zero |

## Verification
The tally is incremental, so a single lost or doubled step stays in it. It shows at the ports in the next cycle, either as a wrong word-1 value or as `irq_out` held high with no active line, and it never heals on its own. A wrong enable bit may stay hidden until that line's level next changes or until word 2 is read. For that reason the reference model is compared every clock, and the tally and lowest active line are read back after every stimulus step. Same-cycle clashes between level changes and commands, along with out-of-range line numbers, are driven on purpose, because those are where an incremental count drifts.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int unsigned WORD_ID      = 0;
  localparam int unsigned WORD_COUNT   = 1;
  localparam int unsigned WORD_CURRENT = 2;
  localparam int unsigned WORD_DIS_ALL = 3;
  localparam int unsigned WORD_DIS_ONE = 4;
  localparam int unsigned WORD_EN_ONE  = 5;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_DIS_ALL = 2'd1,
    CMD_DIS_ONE = 2'd2,
    CMD_EN_ONE  = 2'd3
  } cmd_e;

  localparam logic [31:0] NO_LINE = 32'hFFFF_FFFF;
endpackage

// File: rtl/icc_cmd_decode.sv
module icc_cmd_decode
  import icc_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned IDX_W  = $clog2(N_LINES),
  localparam int unsigned WORD_W = ADDR_W - 2
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output cmd_e              cmd,
  output logic [IDX_W-1:0]  line
);
  localparam logic [WORD_W-1:0] W_DIS_ALL = WORD_W'(WORD_DIS_ALL);
  localparam logic [WORD_W-1:0] W_DIS_ONE = WORD_W'(WORD_DIS_ONE);
  localparam logic [WORD_W-1:0] W_EN_ONE  = WORD_W'(WORD_EN_ONE);

  logic [WORD_W-1:0] word;
  logic              in_range;
  logic              unused_lsb;

  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign in_range   = (bus_wdata < 32'(N_LINES));
  assign line       = bus_wdata[IDX_W-1:0];

  always_comb begin
    cmd = CMD_NONE;
    if (bus_we) begin
      if (word == W_DIS_ALL)                  cmd = CMD_DIS_ALL;
      else if (word == W_DIS_ONE && in_range) cmd = CMD_DIS_ONE;
      else if (word == W_EN_ONE && in_range)  cmd = CMD_EN_ONE;
    end
  end
endmodule

// File: rtl/icc_line_bank.sv
module icc_line_bank
  import icc_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  localparam int unsigned IDX_W  = $clog2(N_LINES),
  localparam int unsigned CNT_W  = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  cmd_e               cmd,
  input  logic [IDX_W-1:0]   line,
  output logic [N_LINES-1:0] lvl_q,
  output logic [N_LINES-1:0] en_q,
  output logic [CNT_W-1:0]   count_q,
  output logic               irq_q
);
  logic [N_LINES-1:0] en_next;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] fall;
  logic [CNT_W-1:0]   n_rise;
  logic [CNT_W-1:0]   n_fall;
  logic               cmd_inc;
  logic               cmd_dec;
  logic [CNT_W-1:0]   count_next;

  // level steps are weighed against the enable held before this edge
  assign rise = irq_in & ~lvl_q & en_q;
  assign fall = ~irq_in & lvl_q & en_q;

  always_comb begin
    n_rise = '0;
    n_fall = '0;
    for (int i = 0; i < int'(N_LINES); i++) begin
      n_rise = n_rise + CNT_W'(rise[i]);
      n_fall = n_fall + CNT_W'(fall[i]);
    end
  end

  // command steps are weighed against the level arriving at this edge,
  // so a clash with a level change still leaves the tally exact
  assign cmd_inc = (cmd == CMD_EN_ONE)  && !en_q[line] &&  irq_in[line];
  assign cmd_dec = (cmd == CMD_DIS_ONE) &&  en_q[line] &&  irq_in[line];

  generate
    for (genvar g = 0; g < int'(N_LINES); g++) begin : g_en
      logic hit;
      assign hit = (line == IDX_W'(g));
      always_comb begin
        en_next[g] = en_q[g];
        unique case (cmd)
          CMD_DIS_ALL: en_next[g] = 1'b0;
          CMD_DIS_ONE: if (hit) en_next[g] = 1'b0;
          CMD_EN_ONE:  if (hit) en_next[g] = 1'b1;
          default:     en_next[g] = en_q[g];
        endcase
      end
    end
  endgenerate

  always_comb begin
    if (cmd == CMD_DIS_ALL) count_next = '0;
    else count_next = count_q + n_rise - n_fall
                      + CNT_W'(cmd_inc) - CNT_W'(cmd_dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      en_q    <= '0;
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      lvl_q   <= irq_in;
      en_q    <= en_next;
      count_q <= count_next;
      irq_q   <= (count_next != '0);
    end
  end
endmodule

// File: rtl/icc_lowest.sv
module icc_lowest #(
  parameter int unsigned N_LINES = 64,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] active,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = int'(N_LINES) - 1; i >= 0; i--) begin
      if (active[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_count_ctrl.sv
module irq_count_ctrl
  import icc_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [31:0] ID_WORD = 32'h1C5A_0001,
  localparam int unsigned IDX_W  = $clog2(N_LINES),
  localparam int unsigned CNT_W  = $clog2(N_LINES + 1),
  localparam int unsigned WORD_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  cmd_e               cmd;
  logic [IDX_W-1:0]   line;
  logic [N_LINES-1:0] lvl_q;
  logic [N_LINES-1:0] en_q;
  logic [CNT_W-1:0]   count_q;
  logic               low_found;
  logic [IDX_W-1:0]   low_idx;
  logic [WORD_W-1:0]  rd_word;

  icc_cmd_decode #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_dec (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cmd      (cmd),
    .line     (line)
  );

  icc_line_bank #(.N_LINES(N_LINES)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .cmd    (cmd),
    .line   (line),
    .lvl_q  (lvl_q),
    .en_q   (en_q),
    .count_q(count_q),
    .irq_q  (irq_out)
  );

  icc_lowest #(.N_LINES(N_LINES)) u_low (
    .active(lvl_q & en_q),
    .found (low_found),
    .idx   (low_idx)
  );

  assign rd_word = bus_addr[ADDR_W-1:2];

  always_comb begin
    bus_rdata = '0;
    if (rd_word == WORD_W'(WORD_ID))           bus_rdata = ID_WORD;
    else if (rd_word == WORD_W'(WORD_COUNT))   bus_rdata = 32'(count_q);
    else if (rd_word == WORD_W'(WORD_CURRENT)) bus_rdata = low_found ? 32'(low_idx) : NO_LINE;
  end
endmodule

// File: rtl/icc_checker.sv
module icc_checker
  import icc_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  localparam int unsigned IDX_W  = $clog2(N_LINES),
  localparam int unsigned CNT_W  = $clog2(N_LINES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] irq_in,
  input cmd_e               cmd,
  input logic [IDX_W-1:0]   line,
  input logic [N_LINES-1:0] lvl_q,
  input logic [N_LINES-1:0] en_q,
  input logic [CNT_W-1:0]   count_q,
  input logic               irq_out
);
  AST_TALLY_MATCHES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    count_q == CNT_W'($countones(lvl_q & en_q))); // R9
  AST_REQUEST_FOLLOWS_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (count_q != '0)); // R3
  AST_LEVEL_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl_q == $past(irq_in)); // R4
  AST_DISALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_DIS_ALL |=> (en_q == '0) && (count_q == '0)); // R7
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_EN_ONE |=> en_q[$past(line)]); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_DIS_ONE |=> !en_q[$past(line)]); // R6
  AST_IDLE_ENABLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_NONE |=> $stable(en_q)); // R2
endmodule

bind irq_count_ctrl icc_checker #(.N_LINES(N_LINES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_in (irq_in),
  .cmd    (cmd),
  .line   (line),
  .lvl_q  (lvl_q),
  .en_q   (en_q),
  .count_q(count_q),
  .irq_out(irq_out)
);

// File: tb/sim_irq_count_ctrl.sv
`timescale 1ns/1ps
module sim_irq_count_ctrl;
  localparam int N = 64;
  localparam logic [31:0] ID = 32'h1C5A_0001;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  logic [N-1:0] m_lvl = '0;
  logic [N-1:0] m_en  = '0;

  always #2 clk = ~clk;

  irq_count_ctrl #(.N_LINES(N), .ADDR_W(12), .ID_WORD(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic int m_count();
    return $countones(m_lvl & m_en);
  endfunction

  function automatic logic [31:0] m_current();
    for (int i = 0; i < N; i++) if (m_lvl[i] && m_en[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every clock: request output against the model (R3)
  always @(negedge clk) if (live) check("R3 irq_out", 32'(irq_out), 32'(m_count() > 0));

  task automatic step(input logic [N-1:0] lines, input logic we,
                      input logic [11:0] addr, input logic [31:0] wd);
    @(negedge clk);
    irq_in = lines; bus_we = we; bus_addr = addr; bus_wdata = wd;
    @(posedge clk);
    if (we) begin
      case (int'(addr[11:2]))
        3: m_en = '0;
        4: if (wd < 32'(N)) m_en[wd[5:0]] = 1'b0;
        5: if (wd < 32'(N)) m_en[wd[5:0]] = 1'b1;
        default: ;
      endcase
    end
    m_lvl = lines;
  endtask

  task automatic rd(input logic [11:0] addr, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = addr;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ln;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    // R1 reset state, R2 identification and undefined words
    check("R1 irq after reset", 32'(irq_out), 32'd0);
    rd(12'h004, 32'd0, "R1 tally after reset");
    rd(12'h008, 32'hFFFF_FFFF, "R1 current after reset");
    rd(12'h000, ID, "R2 id word");
    rd(12'h018, 32'd0, "R2 undefined word 6");
    rd(12'hFFC, 32'd0, "R2 top of window");
    // R4 level on a disabled line is stored but not counted
    ln = '0; ln[5] = 1'b1; ln[0] = 1'b1;
    step(ln, 1'b0, 12'h000, 0);
    rd(12'h004, 32'd0, "R4 disabled line not counted");
    step(ln, 1'b1, 12'h014, 5);
    rd(12'h004, 32'd1, "R5 enable high line");
    check("R3 irq high", 32'(irq_out), 32'd1);
    rd(12'h008, 32'd5, "R8 current line 5");
    step(ln, 1'b1, 12'h014, 5);
    rd(12'h004, 32'd1, "R5 enable twice no double count");
    step(ln, 1'b1, 12'h014, 64);
    rd(12'h004, 32'd1, "R5 out of range enable ignored");
    rd(12'h008, 32'd5, "R5 line 0 untouched by data 64");
    // R9 rise and enable in one clock
    ln[2] = 1'b1;
    step(ln, 1'b1, 12'h014, 2);
    rd(12'h004, 32'd2, "R9 rise with enable same clock");
    rd(12'h008, 32'd2, "R8 lowest enabled active");
    step(ln, 1'b1, 12'h014, 0);
    rd(12'h008, 32'd0, "R8 line 0 now lowest");
    rd(12'h004, 32'd3, "R5 enable counts stored level");
    ln[5] = 1'b0;
    step(ln, 1'b0, 12'h000, 0);
    rd(12'h004, 32'd2, "R4 enabled line fall");
    ln[2] = 1'b0;
    step(ln, 1'b1, 12'h010, 2);
    rd(12'h004, 32'd1, "R9 fall with disable same clock");
    step(ln, 1'b1, 12'h010, 2);
    rd(12'h004, 32'd1, "R6 disable of disabled line");
    step(ln, 1'b1, 12'h010, 200);
    rd(12'h004, 32'd1, "R6 out of range disable ignored");
    step(ln, 1'b1, 12'h004, 99);
    rd(12'h004, 32'd1, "R2 write to tally ignored");
    rd(12'h006, 32'd1, "R10 low address bits ignored");
    step(ln, 1'b1, 12'h00C, 32'hDEAD);
    rd(12'h004, 32'd0, "R7 disable all zeroes tally");
    check("R7 irq low", 32'(irq_out), 32'd0);
    rd(12'h008, 32'hFFFF_FFFF, "R8 none active");
    step(ln, 1'b1, 12'h014, 0);
    rd(12'h004, 32'd1, "R7 level kept over disable all");
    ln[63] = 1'b1;
    step(ln, 1'b1, 12'h014, 63);
    rd(12'h004, 32'd2, "R10 top line enable");
    step(ln, 1'b1, 12'h010, 0);
    rd(12'h008, 32'd63, "R10 top line current");
    // mixed traffic
    for (int k = 0; k < 500; k++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic w;
      if ($urandom % 3 == 0) ln = ln ^ (64'd1 << ($urandom % 64));
      if ($urandom % 4 == 0) ln = ln ^ (64'd1 << ($urandom % 8));
      w = ($urandom % 2 == 0);
      case ($urandom % 20)
        0: a = 12'h00C;
        1, 2, 3, 4, 5, 6, 7, 8: a = 12'h010;
        default: a = 12'h014;
      endcase
      d = ($urandom % 8 == 0) ? 32'($urandom % 80) : 32'($urandom % 10);
      step(ln, w, a, d);
      rd(12'h004, 32'(m_count()), "R9 tally under traffic");
      rd(12'h008, m_current(), "R8 current under traffic");
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule